// File: doc/BRIEF.md
# FIFO Offset Register Load and Readback Port

This block holds the two programmable threshold offsets of a FIFO: the almost-empty offset and the almost-full offset. Both are loaded through the FIFO write data bus on the write clock and can be read back on the FIFO read data bus on the read clock. An offset-select strobe, active low, turns the ordinary write and read enables into offset accesses. Each access goes to the almost-empty offset first and to the almost-full offset next, then back to the almost-empty offset.

A reset sets both offsets to a default that depends on the FIFO depth. Readback is only available while the FIFO runs in standard mode. In fall-through mode an offset read attempt does not change the read data bus. The storage array and the flag comparators sit outside this block and take the two offsets from it.

Top module: `fifo_ofs_port`

## Requirements
- R1: While `rst_n` is low, and after reset until the first offset read, `rd_data` is all zeros.
- R2: Reset loads both offsets with a default set by `DEPTH`: 31 when DEPTH is 256, 63 when DEPTH is 512, 127 for deeper FIFOs.
- R3: On each `wr_clk` rising edge where `ofs_sel_n` and `wr_en_n` are both low, `wr_data[OFS_W-1:0]` is stored into the offset selected by the write slot. The slot starts at the almost-empty offset, moves to the almost-full offset, and wraps back after that.
- R4: On each `rd_clk` rising edge where `ofs_sel_n` and `rd_en_n` are both low and `fall_through` is 0, `rd_data[OFS_W-1:0]` takes the offset selected by the read slot, which then advances. The almost-empty offset comes first, the almost-full offset second, then the slot wraps.
- R5: During an offset readback, `rd_data` bits above `OFS_W-1` are zero.
- R6: With `fall_through` at 1, a read attempt (`ofs_sel_n` and `rd_en_n` low) leaves `rd_data` unchanged and does not advance the read slot.
- R7: A clock edge of either domain that sees `ofs_sel_n` high returns that domain's slot to the almost-empty offset.
- R8: A `rd_clk` edge without an offset read (either `ofs_sel_n` or `rd_en_n` high) leaves `rd_data` unchanged.
- R9: A `wr_clk` edge with `ofs_sel_n` low and `wr_en_n` high changes neither offset nor the write slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock; offset loads happen on its rising edge |
| rd_clk | input | 1 | Read-side clock; offset readback happens on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ofs_sel_n | input | 1 | Offset access select, active low; high restarts both slots |
| wr_en_n | input | 1 | Write enable, active low |
| rd_en_n | input | 1 | Read enable, active low |
| fall_through | input | 1 | 1 selects fall-through mode, 0 selects standard mode |
| wr_data | input | DATA_W | Write data; low OFS_W bits carry the offset being loaded |
| rd_data | output | DATA_W | Read data; low OFS_W bits carry the offset read back |

## Verification
An offset read is due on `rd_data` one `rd_clk` edge after the request: the request is set up after a falling edge, the rising edge registers it, and the value is compared at the next falling edge. The driver pushes each expected value into a queue tagged with that due cycle. The monitor pops it only when the read-clock cycle count reaches it. A load becomes visible only through a later readback, which follows a slot restart. Hold cases (idle, fall-through, write enable high) push the unchanged value for the same one-edge slot, so a wrongly taken access would show up in that same cycle.

// File: rtl/fifo_ofs_pkg.sv
package fifo_ofs_pkg;

   typedef enum logic {
      OFS_EMPTY = 1'b0,
      OFS_FULL  = 1'b1
   } ofs_slot_e;

   localparam int unsigned N_SLOTS = 2;

   // Default threshold offset as a function of FIFO depth
   function automatic int unsigned reset_offset(input int unsigned depth);
      if (depth <= 256) return 31;
      if (depth <= 512) return 63;
      return 127;
   endfunction

endpackage

// File: rtl/fifo_ofs_slot_ptr.sv
module fifo_ofs_slot_ptr
   import fifo_ofs_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      restart,
   input  logic      advance,
   output ofs_slot_e slot
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         slot <= OFS_EMPTY;
      else if (restart)
         slot <= OFS_EMPTY;
      else if (advance)
         slot <= (slot == OFS_EMPTY) ? OFS_FULL : OFS_EMPTY;
   end

endmodule

// File: rtl/fifo_ofs_bank.sv
module fifo_ofs_bank
   import fifo_ofs_pkg::*;
#(
   parameter int unsigned DEPTH = 256,
   parameter int unsigned OFS_W = 12
) (
   input  logic             wr_clk,
   input  logic             rst_n,
   input  logic             wr_go,
   input  ofs_slot_e        slot,
   input  logic [OFS_W-1:0] wr_ofs,
   output logic [OFS_W-1:0] empty_ofs,
   output logic [OFS_W-1:0] full_ofs
);

   localparam logic [OFS_W-1:0] RST_OFS = OFS_W'(reset_offset(DEPTH));

   for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
      localparam ofs_slot_e MY_SLOT = (g == 0) ? OFS_EMPTY : OFS_FULL;
      logic [OFS_W-1:0] q;

      always_ff @(posedge wr_clk or negedge rst_n) begin
         if (!rst_n)
            q <= RST_OFS;
         else if (wr_go && (slot == MY_SLOT))
            q <= wr_ofs;
      end
   end

   assign empty_ofs = g_slot[0].q;
   assign full_ofs  = g_slot[1].q;

endmodule

// File: rtl/fifo_ofs_readout.sv
module fifo_ofs_readout
   import fifo_ofs_pkg::*;
#(
   parameter int unsigned OFS_W = 12
) (
   input  logic             rd_clk,
   input  logic             rst_n,
   input  logic             rd_go,
   input  ofs_slot_e        slot,
   input  logic [OFS_W-1:0] empty_ofs,
   input  logic [OFS_W-1:0] full_ofs,
   output logic [OFS_W-1:0] out_q
);

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n)
         out_q <= '0;
      else if (rd_go)
         out_q <= (slot == OFS_EMPTY) ? empty_ofs : full_ofs;
   end

endmodule

// File: rtl/fifo_ofs_port.sv
module fifo_ofs_port
   import fifo_ofs_pkg::*;
#(
   parameter int unsigned DEPTH  = 256,
   parameter int unsigned DATA_W = 18,
   parameter int unsigned OFS_W  = 12
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              ofs_sel_n,
   input  logic              wr_en_n,
   input  logic              rd_en_n,
   input  logic              fall_through,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);

   localparam int unsigned PAD_W = (DATA_W > OFS_W) ? DATA_W - OFS_W : 0;

   // Elaboration-time parameter checks
   if (OFS_W > DATA_W) begin : g_bad_width
      $error("fifo_ofs_port: OFS_W must not exceed DATA_W");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("fifo_ofs_port: DEPTH must be a power of two");
   end
   if (reset_offset(DEPTH) >= (64'd1 << OFS_W)) begin : g_bad_default
      $error("fifo_ofs_port: default offset does not fit in OFS_W bits");
   end

   logic             wr_go;
   logic             rd_go;
   ofs_slot_e        wr_slot;
   ofs_slot_e        rd_slot;
   logic [OFS_W-1:0] empty_ofs;
   logic [OFS_W-1:0] full_ofs;
   logic [OFS_W-1:0] out_q;

   assign wr_go = !ofs_sel_n && !wr_en_n;
   assign rd_go = !ofs_sel_n && !rd_en_n && !fall_through;

   fifo_ofs_slot_ptr u_wr_ptr (
      .clk     (wr_clk),
      .rst_n   (rst_n),
      .restart (ofs_sel_n),
      .advance (wr_go),
      .slot    (wr_slot)
   );

   fifo_ofs_slot_ptr u_rd_ptr (
      .clk     (rd_clk),
      .rst_n   (rst_n),
      .restart (ofs_sel_n),
      .advance (rd_go),
      .slot    (rd_slot)
   );

   fifo_ofs_bank #(
      .DEPTH (DEPTH),
      .OFS_W (OFS_W)
   ) u_bank (
      .wr_clk    (wr_clk),
      .rst_n     (rst_n),
      .wr_go     (wr_go),
      .slot      (wr_slot),
      .wr_ofs    (wr_data[OFS_W-1:0]),
      .empty_ofs (empty_ofs),
      .full_ofs  (full_ofs)
   );

   fifo_ofs_readout #(
      .OFS_W (OFS_W)
   ) u_readout (
      .rd_clk    (rd_clk),
      .rst_n     (rst_n),
      .rd_go     (rd_go),
      .slot      (rd_slot),
      .empty_ofs (empty_ofs),
      .full_ofs  (full_ofs),
      .out_q     (out_q)
   );

   if (PAD_W > 0) begin : g_pad
      logic unused_wr_hi;
      assign unused_wr_hi = ^wr_data[DATA_W-1:OFS_W];
      assign rd_data      = {{PAD_W{1'b0}}, out_q};
   end else begin : g_nopad
      assign rd_data = out_q;
   end

endmodule

// File: rtl/fifo_ofs_port_chk.sv
module fifo_ofs_port_chk #(
   parameter int unsigned DATA_W = 18,
   parameter int unsigned OFS_W  = 12
) (
   input logic              wr_clk,
   input logic              rd_clk,
   input logic              rst_n,
   input logic              ofs_sel_n,
   input logic              wr_en_n,
   input logic              rd_en_n,
   input logic              fall_through,
   input logic [OFS_W-1:0]  wr_ofs,
   input logic [DATA_W-1:0] rd_data,
   input logic [OFS_W-1:0]  empty_ofs,
   input logic [OFS_W-1:0]  full_ofs,
   input logic              rd_slot,
   input logic              wr_slot
);

   logic rd_req;
   logic wr_req;
   assign rd_req = !ofs_sel_n && !rd_en_n && !fall_through;
   assign wr_req = !ofs_sel_n && !wr_en_n;

   AST_RD_EMPTY_FIRST: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (rd_req && !rd_slot) |=> rd_data[OFS_W-1:0] == $past(empty_ofs)); // R4
   AST_RD_FULL_NEXT: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (rd_req && rd_slot) |=> rd_data[OFS_W-1:0] == $past(full_ofs)); // R4
   AST_RD_SLOT_ADVANCE: assert property (@(posedge rd_clk) disable iff (!rst_n)
      rd_req |=> rd_slot != $past(rd_slot)); // R4
   AST_FWFT_NO_OUT: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!ofs_sel_n && !rd_en_n && fall_through) |=> ($stable(rd_data) && $stable(rd_slot))); // R6
   AST_IDLE_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (ofs_sel_n || rd_en_n) |=> $stable(rd_data)); // R8
   AST_RD_RESTART: assert property (@(posedge rd_clk) disable iff (!rst_n)
      ofs_sel_n |=> !rd_slot); // R7
   AST_WR_RESTART: assert property (@(posedge wr_clk) disable iff (!rst_n)
      ofs_sel_n |=> !wr_slot); // R7
   AST_WR_EMPTY_LOAD: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (wr_req && !wr_slot) |=> empty_ofs == $past(wr_ofs)); // R3
   AST_WR_FULL_LOAD: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (wr_req && wr_slot) |=> full_ofs == $past(wr_ofs)); // R3
   AST_WR_HOLD: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (!ofs_sel_n && wr_en_n) |=>
         ($stable(wr_slot) && $stable(empty_ofs) && $stable(full_ofs))); // R9

endmodule

bind fifo_ofs_port fifo_ofs_port_chk #(
   .DATA_W (DATA_W),
   .OFS_W  (OFS_W)
) u_chk (
   .wr_clk       (wr_clk),
   .rd_clk       (rd_clk),
   .rst_n        (rst_n),
   .ofs_sel_n    (ofs_sel_n),
   .wr_en_n      (wr_en_n),
   .rd_en_n      (rd_en_n),
   .fall_through (fall_through),
   .wr_ofs       (wr_data[OFS_W-1:0]),
   .rd_data      (rd_data),
   .empty_ofs    (empty_ofs),
   .full_ofs     (full_ofs),
   .rd_slot      (rd_slot),
   .wr_slot      (wr_slot)
);

// File: tb/fifo_ofs_port_bench.sv
module fifo_ofs_port_bench;

   localparam int unsigned DEPTH  = 256;
   localparam int unsigned DATA_W = 18;
   localparam int unsigned OFS_W  = 12;
   localparam logic [DATA_W-1:0] DEF_OFS = 18'd31;  // R2: default for 256 deep

   logic              wr_clk = 1'b0;
   logic              rd_clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ofs_sel_n = 1'b1;
   logic              wr_en_n = 1'b1;
   logic              rd_en_n = 1'b1;
   logic              fall_through = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [DATA_W-1:0] rd_data;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   int                due_q[$];
   logic [DATA_W-1:0] val_q[$];
   string             tag_q[$];

   fifo_ofs_port #(
      .DEPTH  (DEPTH),
      .DATA_W (DATA_W),
      .OFS_W  (OFS_W)
   ) u_fifo_ofs_port (
      .wr_clk       (wr_clk),
      .rd_clk       (rd_clk),
      .rst_n        (rst_n),
      .ofs_sel_n    (ofs_sel_n),
      .wr_en_n      (wr_en_n),
      .rd_en_n      (rd_en_n),
      .fall_through (fall_through),
      .wr_data      (wr_data),
      .rd_data      (rd_data)
   );

   // 100 MHz clocks; write clock lags by 3 ns
   always #5 rd_clk = ~rd_clk;
   initial begin
      #3;
      forever #5 wr_clk = ~wr_clk;
   end

   always @(posedge rd_clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag,
                        input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: rd_data=0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic push_exp(input logic [DATA_W-1:0] v, input string tag);
      due_q.push_back(cyc + 1);
      val_q.push_back(v);
      tag_q.push_back(tag);
   endtask

   // Monitor: compare each expected item in its due read-clock cycle
   always @(negedge rd_clk) begin
      while (due_q.size() > 0 && due_q[0] <= cyc) begin
         logic [DATA_W-1:0] v;
         string t;
         void'(due_q.pop_front());
         v = val_q.pop_front();
         t = tag_q.pop_front();
         check(rd_data === v, t, rd_data, v);
      end
   end

   // Driver tasks
   task automatic rd_op(input bit fwft, input logic [DATA_W-1:0] exp, input string tag);
      @(negedge rd_clk);
      ofs_sel_n    = 1'b0;
      rd_en_n      = 1'b0;
      fall_through = fwft;
      push_exp(exp, tag);
   endtask

   task automatic rd_idle(input logic [DATA_W-1:0] exp, input string tag);
      @(negedge rd_clk);
      ofs_sel_n = 1'b0;
      rd_en_n   = 1'b1;
      push_exp(exp, tag);
   endtask

   task automatic restart();
      @(negedge rd_clk);
      ofs_sel_n    = 1'b1;
      rd_en_n      = 1'b1;
      fall_through = 1'b0;
      @(negedge rd_clk);
   endtask

   task automatic wr_op(input logic [DATA_W-1:0] v);
      @(negedge wr_clk);
      ofs_sel_n = 1'b0;
      wr_en_n   = 1'b0;
      rd_en_n   = 1'b1;
      wr_data   = v;
   endtask

   task automatic wr_skip(input logic [DATA_W-1:0] v);
      @(negedge wr_clk);
      ofs_sel_n = 1'b0;
      wr_en_n   = 1'b1;
      rd_en_n   = 1'b1;
      wr_data   = v;
   endtask

   task automatic wr_end();
      @(negedge wr_clk);
      wr_en_n   = 1'b1;
      ofs_sel_n = 1'b1;
      @(negedge wr_clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge rd_clk);
      check(rd_data === '0, "R1 during reset", rd_data, '0);
      rst_n = 1'b1;
      @(negedge rd_clk);
      @(negedge rd_clk);
      check(rd_data === '0, "R1 after reset", rd_data, '0);

      // Defaults read back in order, then wrap
      restart();
      rd_op(1'b0, DEF_OFS, "R2 default empty offset");
      rd_op(1'b0, DEF_OFS, "R2 default full offset");
      rd_op(1'b0, DEF_OFS, "R4 wrap to empty");
      restart();

      // Load with upper data bits set; only low 12 bits are kept
      wr_op(18'h3F0A5);
      wr_op(18'h2B3C1);
      wr_end();
      restart();
      rd_op(1'b0, 18'h000A5, "R3 empty loaded, R5 upper zero");
      rd_op(1'b0, 18'h003C1, "R3 full loaded, R5 upper zero");
      rd_op(1'b0, 18'h000A5, "R4 read slot wraps");
      restart();

      // Read slot restart via select high
      rd_op(1'b0, 18'h000A5, "R4 first read");
      restart();
      rd_op(1'b0, 18'h000A5, "R7 read slot back to empty");
      restart();

      // Idle cycle holds output and slot
      rd_op(1'b0, 18'h000A5, "R4 empty before idle");
      rd_idle(18'h000A5, "R8 idle keeps rd_data");
      rd_op(1'b0, 18'h003C1, "R8 slot kept over idle");
      restart();

      // Fall-through mode blocks readback
      rd_op(1'b0, 18'h000A5, "R4 empty before fall-through");
      rd_op(1'b1, 18'h000A5, "R6 fall-through read leaves rd_data");
      rd_op(1'b0, 18'h003C1, "R6 slot not advanced");
      restart();

      // Write enable high: nothing stored
      wr_skip(18'h00FFF);
      wr_skip(18'h00ABC);
      wr_end();
      restart();
      rd_op(1'b0, 18'h000A5, "R9 empty offset untouched");
      rd_op(1'b0, 18'h003C1, "R9 full offset untouched");
      restart();

      // Three loads: write slot wraps onto the empty offset
      wr_op(18'h00111);
      wr_op(18'h00222);
      wr_op(18'h00333);
      wr_end();
      restart();
      rd_op(1'b0, 18'h00333, "R3 write slot wrap");
      rd_op(1'b0, 18'h00222, "R3 full kept");
      restart();

      // Write slot restart via select high
      wr_op(18'h00444);
      @(negedge wr_clk);
      ofs_sel_n = 1'b1;
      wr_en_n   = 1'b1;
      wr_op(18'h00555);
      wr_end();
      restart();
      rd_op(1'b0, 18'h00555, "R7 write slot back to empty");
      rd_op(1'b0, 18'h00222, "R7 full not overwritten");
      restart();

      repeat (3) @(negedge rd_clk);
      if (due_q.size() != 0) begin
         checks++;
         errors++;
         $display("FAIL R4: %0d expected reads never compared, expected 0", due_q.size());
      end
      finish_run();
   end

endmodule